// File: doc/BRIEF.md
# NAND Flash Command Interface Decoder

This block is the device-side front end of a small NAND flash. It watches an 8-bit shared I/O bus with chip enable, write strobe, command latch and address latch lines, all already synchronous to the block clock. It decodes opcodes, counts address cycles and builds a 19-bit byte address from them. It checks the erase and program confirm cycles. Once a sequence is complete and legal, it emits a one-cycle operation request with an operation code. A busy input stands in for the array controller. While busy is high, only the commands that may run during an operation are let through.

Illegal bytes raise an error pulse instead of a request. A sequence broken by an early command byte raises a separate sequence-error pulse. The array, the high-voltage timing and the read data path sit outside this block.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A bus byte is taken only on the clock after the write strobe `we_n_i` rises while `ce_n_i` is low. With `ce_n_i` high the byte has no effect on any output.
- R2: A byte is a command when `cle_i`=1 and `ale_i`=0, and an address when `ale_i`=1 and `cle_i`=0. With both low or both high the byte is ignored.
- R3: Requests appear on `op_valid_o` for exactly one cycle, together with a code on `op_kind_o`: 1 read, 2 program, 3 erase, 4 status, 5 identify, 6 reset. Opcode 70h requests status at once, 90h requests identify at once and FFh requests reset at once.
- R4: Opcode 00h is followed by three address bytes, and the read request is issued on the third. `addr_o[4:0]` takes bits [4:0] of the first byte, `addr_o[12:5]` takes the second byte and `addr_o[18:13]` takes bits [5:0] of the third.
- R5: Opcode 80h is followed by three address bytes with the same mapping as R4. The program request is issued only on the confirm opcode 10h.
- R6: Opcode 60h is followed by two row bytes, the first into `addr_o[12:5]` and the second (bits [5:0]) into `addr_o[18:13]`, with `addr_o[4:0]`=0. The erase request is issued only on confirm D0h, and `blk_o` then equals `addr_o[18:12]`.
- R7: An undefined opcode, or a 10h/D0h outside its confirm slot, pulses `cmd_err_o` for one cycle and issues no request.
- R8: While `busy_i` is high, only FFh and 70h produce a request. Any other command, and a byte that would complete a read, program or erase, pulses `cmd_err_o` and drops the sequence.
- R9: A command byte that arrives while address bytes are still due, or one that is not the expected confirm, pulses `seq_err_o`, drops the pending sequence and is then decoded as a fresh command.
- R10: Address bytes received outside an address phase, including those beyond the required count, leave `addr_o` unchanged and issue no request.
- R11: After reset, `op_valid_o`, `op_kind_o`, `cmd_err_o`, `seq_err_o` and `addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write strobe, active low, byte taken on its rise |
| cle_i | input | 1 | Marks the bus byte as a command |
| ale_i | input | 1 | Marks the bus byte as an address |
| io_i | input | 8 | Shared command/address bus |
| busy_i | input | 1 | Array operation in progress |
| op_valid_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 3 | Requested operation code |
| addr_o | output | 19 | Assembled byte address |
| blk_o | output | 7 | Erase block number |
| cmd_err_o | output | 1 | Illegal or rejected command pulse |
| seq_err_o | output | 1 | Aborted sequence pulse |

## Verification
The bench builds the block with its default field widths: a 5-bit column, a 14-bit row and a 7-bit block. With these widths the high row byte supplies only six bits, so bench patterns put ones into the dropped upper bits and show that they never leak into `addr_o`. The erase block number spans the boundary between the two row bytes, so a single erase sequence shows that the low row byte's top bit and the high row byte are joined correctly.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_PROG  = 3'd2,
    OP_ERASE = 3'd3,
    OP_STAT  = 3'd4,
    OP_ID    = 3'd5,
    OP_RST   = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_CONF = 2'd2
  } seq_st_e;

  localparam logic [7:0] OPC_RST     = 8'hFF;
  localparam logic [7:0] OPC_READ    = 8'h00;
  localparam logic [7:0] OPC_PROG    = 8'h80;
  localparam logic [7:0] OPC_PROG_GO = 8'h10;
  localparam logic [7:0] OPC_ERASE   = 8'h60;
  localparam logic [7:0] OPC_ERASE_GO= 8'hD0;
  localparam logic [7:0] OPC_STAT    = 8'h70;
  localparam logic [7:0] OPC_ID      = 8'h90;
endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          cle_i,
  input  logic          ale_i,
  output logic          cmd_stb_o,
  output logic          addr_stb_o
);
  logic we_q;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_n_i;
  end

  assign rise       = we_n_i & ~we_q & ~ce_n_i;
  assign cmd_stb_o  = rise & cle_i & ~ale_i;
  assign addr_stb_o = rise & ale_i & ~cle_i;
endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
  parameter int DW    = 8,
  parameter int COL_W = 5,
  parameter int ROW_W = 14,
  localparam int HI_W   = ROW_W - DW,
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              row_only_i,
  input  logic [DW-1:0]     byte_i,
  output logic [1:0]        cnt_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [1:0]       cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      col_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_q + 2'd1;
      case (cnt_q)
        2'd0: if (row_only_i) lo_q <= byte_i;
              else            col_q <= byte_i[COL_W-1:0];
        2'd1: if (row_only_i) hi_q <= byte_i[HI_W-1:0];
              else            lo_q <= byte_i;
        default: hi_q <= byte_i[HI_W-1:0];
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign addr_o = {hi_q, lo_q, col_q};
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_stb_i,
  input  logic          addr_stb_i,
  input  logic [DW-1:0] byte_i,
  input  logic          busy_i,
  input  logic [1:0]    cnt_i,
  output logic          clr_o,
  output logic          take_o,
  output logic          row_only_o,
  output logic          op_valid_o,
  output op_e           op_kind_o,
  output logic          cmd_err_o,
  output logic          seq_err_o
);
  seq_st_e st_q, st_d;
  op_e     pend_q, pend_d;
  logic    v_d, ce_d, se_d;
  op_e     k_d;
  logic    v_q, ce_q, se_q;
  op_e     k_q;
  logic [7:0] conf_code;
  logic [1:0] last_cnt;
  logic       conf_hit;

  assign conf_code = (pend_q == OP_PROG) ? OPC_PROG_GO : OPC_ERASE_GO;
  assign last_cnt  = (pend_q == OP_ERASE) ? 2'd1 : 2'd2;
  assign conf_hit  = (st_q == ST_CONF) && (byte_i[7:0] == conf_code);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    v_d    = 1'b0;
    k_d    = OP_NONE;
    ce_d   = 1'b0;
    se_d   = 1'b0;
    clr_o  = 1'b0;
    take_o = 1'b0;
    if (cmd_stb_i) begin
      st_d = ST_IDLE;
      if (conf_hit) begin
        if (busy_i) ce_d = 1'b1;
        else begin
          v_d = 1'b1;
          k_d = pend_q;
        end
      end else begin
        // abort of an unfinished sequence, byte then decoded afresh
        if (st_q != ST_IDLE) se_d = 1'b1;
        case (byte_i[7:0])
          OPC_RST:  begin v_d = 1'b1; k_d = OP_RST;  end
          OPC_STAT: begin v_d = 1'b1; k_d = OP_STAT; end
          OPC_ID: begin
            if (busy_i) ce_d = 1'b1;
            else begin v_d = 1'b1; k_d = OP_ID; end
          end
          OPC_READ, OPC_PROG, OPC_ERASE: begin
            if (busy_i) ce_d = 1'b1;
            else begin
              st_d  = ST_ADDR;
              clr_o = 1'b1;
              pend_d = (byte_i[7:0] == OPC_READ) ? OP_READ :
                       (byte_i[7:0] == OPC_PROG) ? OP_PROG : OP_ERASE;
            end
          end
          default: ce_d = 1'b1;
        endcase
      end
    end else if (addr_stb_i && st_q == ST_ADDR) begin
      take_o = 1'b1;
      if (cnt_i == last_cnt) begin
        if (pend_q != OP_READ) st_d = ST_CONF;
        else begin
          st_d = ST_IDLE;
          if (busy_i) ce_d = 1'b1;
          else begin v_d = 1'b1; k_d = OP_READ; end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= OP_NONE;
      v_q    <= 1'b0;
      k_q    <= OP_NONE;
      ce_q   <= 1'b0;
      se_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      v_q    <= v_d;
      k_q    <= k_d;
      ce_q   <= ce_d;
      se_q   <= se_d;
    end
  end

  assign row_only_o = (pend_q == OP_ERASE);
  assign op_valid_o = v_q;
  assign op_kind_o  = k_q;
  assign cmd_err_o  = ce_q;
  assign seq_err_o  = se_q;
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_cmd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int COL_W = 5,
  parameter int ROW_W = 14,
  parameter int BLK_W = 7,
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic [DW-1:0]     io_i,
  input  logic              busy_i,
  output logic              op_valid_o,
  output logic [2:0]        op_kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              cmd_err_o,
  output logic              seq_err_o
);
  logic       cmd_stb, addr_stb;
  logic       clr, take, row_only;
  logic [1:0] cnt;
  op_e        kind;

  nand_bus_sampler #(.DW(DW)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_n_i     (ce_n_i),
    .we_n_i     (we_n_i),
    .cle_i      (cle_i),
    .ale_i      (ale_i),
    .cmd_stb_o  (cmd_stb),
    .addr_stb_o (addr_stb)
  );

  nand_addr_collect #(.DW(DW), .COL_W(COL_W), .ROW_W(ROW_W)) u_adr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .take_i     (take),
    .row_only_i (row_only),
    .byte_i     (io_i),
    .cnt_o      (cnt),
    .addr_o     (addr_o)
  );

  nand_seq_fsm #(.DW(DW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_stb_i  (cmd_stb),
    .addr_stb_i (addr_stb),
    .byte_i     (io_i),
    .busy_i     (busy_i),
    .cnt_i      (cnt),
    .clr_o      (clr),
    .take_o     (take),
    .row_only_o (row_only),
    .op_valid_o (op_valid_o),
    .op_kind_o  (kind),
    .cmd_err_o  (cmd_err_o),
    .seq_err_o  (seq_err_o)
  );

  assign op_kind_o = kind;
  assign blk_o     = addr_o[ADDR_W-1 -: BLK_W];
endmodule

// File: rtl/nand_cmd_chk.sv
module nand_cmd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_n_i,
  input logic       we_n_i,
  input logic       cle_i,
  input logic       ale_i,
  input logic       busy_i,
  input logic       op_valid_o,
  input logic [2:0] op_kind_o,
  input logic       cmd_err_o,
  input logic       seq_err_o
);
  p_we_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o || cmd_err_o || seq_err_o) |-> $past(we_n_i && !ce_n_i) && $past(!we_n_i, 2));

  p_byte_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(cle_i ^ ale_i));

  p_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);

  p_kind_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (op_kind_o != 3'd0) && (op_kind_o <= 3'd6));

  p_err_no_op_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> !op_valid_o);

  p_busy_subset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && $past(busy_i)) |-> (op_kind_o == 3'd4 || op_kind_o == 3'd6));

  p_seq_on_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> $past(cle_i && !ale_i));
endmodule

bind nand_cmd_decoder nand_cmd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_n_i     (ce_n_i),
  .we_n_i     (we_n_i),
  .cle_i      (cle_i),
  .ale_i      (ale_i),
  .busy_i     (busy_i),
  .op_valid_o (op_valid_o),
  .op_kind_o  (op_kind_o),
  .cmd_err_o  (cmd_err_o),
  .seq_err_o  (seq_err_o)
);

// File: tb/sim_nand_cmd_decoder.sv
module sim_nand_cmd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_n_i = 1'b1, we_n_i = 1'b1, cle_i = 1'b0, ale_i = 1'b0, busy_i = 1'b0;
  logic [7:0]  io_i = '0;
  logic        op_valid_o, cmd_err_o, seq_err_o;
  logic [2:0]  op_kind_o;
  logic [18:0] addr_o;
  logic [6:0]  blk_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  nand_cmd_decoder u0 (.*);

  typedef struct packed {
    logic        cen, cle, ale, bsy;
    logic [7:0]  dat;
    logic        ev;
    logic [2:0]  ek;
    logic        ece, ese, ca;
    logic [18:0] ea;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t TBL [NV] = '{
    // R4 read: 00h then three address bytes, extra high bits dropped
    '{1'b0,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd4},
    '{1'b0,1'b0,1'b1,1'b0,8'hFF, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd4},
    '{1'b0,1'b0,1'b1,1'b0,8'hA5, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd4},
    '{1'b0,1'b0,1'b1,1'b0,8'hEC, 1'b1,3'd1,1'b0,1'b0,1'b1,{6'h2C,8'hA5,5'h1F}, 4'd4},
    // R10 extra address byte ignored
    '{1'b0,1'b0,1'b1,1'b0,8'h77, 1'b0,3'd0,1'b0,1'b0,1'b1,{6'h2C,8'hA5,5'h1F}, 4'd10},
    // R5 program with 10h confirm
    '{1'b0,1'b1,1'b0,1'b0,8'h80, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd5},
    '{1'b0,1'b0,1'b1,1'b0,8'h03, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd5},
    '{1'b0,1'b0,1'b1,1'b0,8'h10, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd5},
    '{1'b0,1'b0,1'b1,1'b0,8'h01, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd5},
    '{1'b0,1'b1,1'b0,1'b0,8'h10, 1'b1,3'd2,1'b0,1'b0,1'b1,{6'h01,8'h10,5'h03}, 4'd5},
    // R6 erase, two row bytes and D0h confirm
    '{1'b0,1'b1,1'b0,1'b0,8'h60, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd6},
    '{1'b0,1'b0,1'b1,1'b0,8'h80, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd6},
    '{1'b0,1'b0,1'b1,1'b0,8'h15, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd6},
    '{1'b0,1'b1,1'b0,1'b0,8'hD0, 1'b1,3'd3,1'b0,1'b0,1'b1,{6'h15,8'h80,5'h00}, 4'd6},
    // R3 immediate commands
    '{1'b0,1'b1,1'b0,1'b0,8'h70, 1'b1,3'd4,1'b0,1'b0,1'b0,19'h0, 4'd3},
    '{1'b0,1'b1,1'b0,1'b0,8'h90, 1'b1,3'd5,1'b0,1'b0,1'b0,19'h0, 4'd3},
    '{1'b0,1'b1,1'b0,1'b0,8'hFF, 1'b1,3'd6,1'b0,1'b0,1'b0,19'h0, 4'd3},
    // R7 illegal opcodes and stray confirms
    '{1'b0,1'b1,1'b0,1'b0,8'h55, 1'b0,3'd0,1'b1,1'b0,1'b0,19'h0, 4'd7},
    '{1'b0,1'b1,1'b0,1'b0,8'h10, 1'b0,3'd0,1'b1,1'b0,1'b0,19'h0, 4'd7},
    '{1'b0,1'b1,1'b0,1'b0,8'hD0, 1'b0,3'd0,1'b1,1'b0,1'b0,19'h0, 4'd7},
    // R9 command during address phase
    '{1'b0,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd9},
    '{1'b0,1'b0,1'b1,1'b0,8'h01, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd9},
    '{1'b0,1'b1,1'b0,1'b0,8'h70, 1'b1,3'd4,1'b0,1'b1,1'b0,19'h0, 4'd9},
    // R9 wrong confirm for erase, then decoded as stray 10h
    '{1'b0,1'b1,1'b0,1'b0,8'h60, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd9},
    '{1'b0,1'b0,1'b1,1'b0,8'h01, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd9},
    '{1'b0,1'b0,1'b1,1'b0,8'h02, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd9},
    '{1'b0,1'b1,1'b0,1'b0,8'h10, 1'b0,3'd0,1'b1,1'b1,1'b0,19'h0, 4'd9},
    // R8 busy subset
    '{1'b0,1'b1,1'b0,1'b1,8'h00, 1'b0,3'd0,1'b1,1'b0,1'b0,19'h0, 4'd8},
    '{1'b0,1'b1,1'b0,1'b1,8'h70, 1'b1,3'd4,1'b0,1'b0,1'b0,19'h0, 4'd8},
    '{1'b0,1'b1,1'b0,1'b1,8'hFF, 1'b1,3'd6,1'b0,1'b0,1'b0,19'h0, 4'd8},
    '{1'b0,1'b1,1'b0,1'b1,8'h90, 1'b0,3'd0,1'b1,1'b0,1'b0,19'h0, 4'd8},
    '{1'b0,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd8},
    '{1'b0,1'b0,1'b1,1'b0,8'h01, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd8},
    '{1'b0,1'b0,1'b1,1'b0,8'h02, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd8},
    '{1'b0,1'b0,1'b1,1'b1,8'h03, 1'b0,3'd0,1'b1,1'b0,1'b0,19'h0, 4'd8},
    // R2 data byte and both latches high ignored
    '{1'b0,1'b0,1'b0,1'b0,8'h70, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd2},
    '{1'b0,1'b1,1'b1,1'b0,8'h70, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd2},
    // R1 chip not enabled
    '{1'b1,1'b1,1'b0,1'b0,8'h70, 1'b0,3'd0,1'b0,1'b0,1'b0,19'h0, 4'd1}
  };

  task automatic bus_cycle(input logic cen, cle, ale, bsy, input logic [7:0] d);
    @(negedge clk_i);
    ce_n_i = cen; cle_i = cle; ale_i = ale; busy_i = bsy; io_i = d; we_n_i = 1'b0;
    @(negedge clk_i);
    we_n_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic idle_bus();
    cle_i = 1'b0; ale_i = 1'b0; busy_i = 1'b0; ce_n_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    n_chk++;
    if (op_valid_o !== 1'b0 || op_kind_o !== 3'd0 || cmd_err_o !== 1'b0 ||
        seq_err_o !== 1'b0 || addr_o !== 19'h0) begin
      n_fail++;
      $display("FAIL R11 reset: v=%b k=%0d ce=%b se=%b a=%h exp all zero",
               op_valid_o, op_kind_o, cmd_err_o, seq_err_o, addr_o);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      bus_cycle(TBL[i].cen, TBL[i].cle, TBL[i].ale, TBL[i].bsy, TBL[i].dat);
      n_chk++;
      if (op_valid_o !== TBL[i].ev || cmd_err_o !== TBL[i].ece || seq_err_o !== TBL[i].ese ||
          (TBL[i].ev && op_kind_o !== TBL[i].ek) || (TBL[i].ca && addr_o !== TBL[i].ea)) begin
        n_fail++;
        $display("FAIL R%0d row %0d: v=%b k=%0d ce=%b se=%b a=%h exp v=%b k=%0d ce=%b se=%b a=%h",
                 TBL[i].rq, i, op_valid_o, op_kind_o, cmd_err_o, seq_err_o, addr_o,
                 TBL[i].ev, TBL[i].ek, TBL[i].ece, TBL[i].ese, TBL[i].ea);
      end
      idle_bus();
    end
    // R3 pulse lasts one cycle
    bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 8'h70);
    idle_bus();
    @(negedge clk_i);
    n_chk++;
    if (op_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 pulse width: v=%b exp 0", op_valid_o);
    end
    // R6 erase block number across the row byte boundary
    bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 8'h60);
    bus_cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'h80);
    bus_cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'hD5);
    bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 8'hD0);
    n_chk++;
    if (op_valid_o !== 1'b1 || op_kind_o !== 3'd3 || blk_o !== 7'h2B) begin
      n_fail++;
      $display("FAIL R6 block: v=%b k=%0d blk=%h exp v=1 k=3 blk=2b", op_valid_o, op_kind_o, blk_o);
    end
    idle_bus();
    // R1 strobe held low across command change gives nothing until it rises
    @(negedge clk_i);
    ce_n_i = 1'b0; cle_i = 1'b1; io_i = 8'h55; we_n_i = 1'b0;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (cmd_err_o !== 1'b0 || op_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 no rise: ce=%b v=%b exp 0 0", cmd_err_o, op_valid_o);
    end
    io_i = 8'h90; we_n_i = 1'b1;
    @(negedge clk_i);
    n_chk++;
    if (op_valid_o !== 1'b1 || op_kind_o !== 3'd5) begin
      n_fail++;
      $display("FAIL R1 rise: v=%b k=%0d exp 1 5", op_valid_o, op_kind_o);
    end
    idle_bus();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule